// File: doc/BRIEF.md
# Tick-Sampled Buffer Fill Frequency Controller

This block sits beside the receive-side elastic buffers of one network node. It steers that node's local oscillator. It counts local clock ticks, never wall-clock time. Once every `period` ticks it takes a snapshot of the fill level of every neighbour buffer. The snapshot is taken one clock cycle after the tick edge, so it never lands on the edge at which a frame leaves a buffer.

From that snapshot the block forms a signed error. The error is the sum over all links of (fill minus a per-link target fill). The error is multiplied by a signed gain and clamped to the signed range of the oscillator's frequency-offset register. The clamped value is written to that register `delay` ticks after the sample tick, and a one-cycle write strobe goes with it. Between two writes the register holds its value, so the commanded frequency is piecewise constant.

The block uses only local fill counts. It has no path to other nodes and does not look at frame contents.

Top module: `occ_freq_ctrl`

## Requirements
- R1: Ticks are counted from reset, with the first tick numbered 0. Tick number k is a sample tick when k is a multiple of `period`. Clock cycles with `tick` low do not advance the count.
- R2: The fill levels and the gain used for a sample are the values present on the clock cycle after the sample tick, not the values present during the tick cycle itself.
- R3: The correction computed from the sample at tick k is written at the edge of tick k+`delay`. If that write edge is the same edge that captures the sample, the freshly captured value is written.
- R4: `corr_wr` is high for exactly the one clock cycle after each write edge and low in every other cycle.
- R5: `corr` changes only on a cycle in which `corr_wr` is high, and holds its value otherwise.
- R6: The correction equals `gain` × Σ(`occ_lvl`[i] − `occ_ref`[i]). Link i occupies bits [i·OCC_W +: OCC_W] of each bus. Fill and target values are unsigned, `gain` is two's complement, and `corr` is two's complement.
- R7: A result outside [−2^(OUT_W−1), 2^(OUT_W−1)−1] is clamped to the nearer limit and never wraps.
- R8: After reset, `corr` is 0 and `corr_wr` is 0 until the first write, which happens at tick number `delay`.
- R9: When every link's fill equals its target, the written correction is 0 for any gain.
- R10: `period` and `delay` are unsigned. Correct operation requires 1 ≤ `delay` < `period`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per local tick; frames leave the buffers on this edge |
| occ_lvl | input | N_LINKS*OCC_W | Fill level of each neighbour buffer |
| occ_ref | input | N_LINKS*OCC_W | Target fill for each link |
| gain | input | GAIN_W | Signed proportional gain |
| period | input | CNT_W | Ticks between samples |
| delay | input | CNT_W | Ticks from a sample to its write |
| corr | output | OUT_W | Signed frequency-offset word |
| corr_wr | output | 1 | Write strobe for `corr` |

## Verification
A write is due at the edge of tick number m·`period`+`delay`. Both `corr` and `corr_wr` reflect it in the cycle that follows, so the bench checks them at the falling edge right after every tick. It also checks every idle cycle in between, expecting the strobe low and the word unchanged.

The bench changes the fill levels just after each sample tick edge. Its expected value is built from the post-edge levels only, so a design that captures during the tick cycle gets the wrong sum. Gaps of zero, one and two idle cycles between ticks are mixed in. With `delay`=1 this makes the capture edge and the write edge coincide.

// File: rtl/occ_ctrl_pkg.sv
package occ_ctrl_pkg;

  // Clamp a signed value to the range of a w-bit two's complement word.
  function automatic longint clamp_signed(longint v, int unsigned w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/ofc_tick_sched.sv
module ofc_tick_sched #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] delay,
  output logic             sample_evt,
  output logic             apply_evt,
  output logic             capture
);
  logic [CNT_W-1:0] ph_q;

  // Phase advances only on local ticks (R1).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= '0;
      capture <= 1'b0;
    end else begin
      capture <= sample_evt;
      if (tick) ph_q <= (ph_q >= period - CNT_W'(1)) ? '0 : ph_q + CNT_W'(1);
    end
  end

  assign sample_evt = tick && (ph_q == '0);
  assign apply_evt  = tick && (ph_q == delay);

  // Capture is always the cycle after a tick edge, never on it.
  AST_CAPTURE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> $past(tick)); // R2

  AST_EVENTS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (delay != '0) |-> !(sample_evt && apply_evt)); // R10
endmodule

// File: rtl/ofc_err_sum.sv
module ofc_err_sum #(
  parameter int N_LINKS = 3,
  parameter int OCC_W   = 8,
  parameter int SUM_W   = OCC_W + 1 + $clog2(N_LINKS)
) (
  input  logic [N_LINKS*OCC_W-1:0] occ_lvl,
  input  logic [N_LINKS*OCC_W-1:0] occ_ref,
  output logic signed [SUM_W-1:0]  err_sum
);
  logic signed [OCC_W:0] diff [N_LINKS];

  // One signed difference per link: fill minus target (R6).
  for (genvar i = 0; i < N_LINKS; i++) begin : g_diff
    assign diff[i] = $signed({1'b0, occ_lvl[i*OCC_W +: OCC_W]})
                   - $signed({1'b0, occ_ref[i*OCC_W +: OCC_W]});
  end

  always_comb begin
    err_sum = '0;
    for (int i = 0; i < N_LINKS; i++) err_sum = err_sum + SUM_W'(diff[i]);
  end
endmodule

// File: rtl/ofc_gain_sat.sv
module ofc_gain_sat #(
  parameter int SUM_W  = 11,
  parameter int GAIN_W = 8,
  parameter int OUT_W  = 10
) (
  input  logic signed [SUM_W-1:0]  err_sum,
  input  logic signed [GAIN_W-1:0] gain,
  output logic signed [OUT_W-1:0]  val_o
);
  localparam int PROD_W = SUM_W + GAIN_W;

  logic signed [PROD_W-1:0] prod;

  assign prod  = err_sum * gain;
  assign val_o = OUT_W'(occ_ctrl_pkg::clamp_signed(longint'(prod), OUT_W));

  // Clamping keeps the sign of the product (R7).
  always_comb begin
    AST_SAT_SIGN: assert ((prod < 0) == (val_o < 0)) else $error("sign lost in clamp"); // R7
  end
endmodule

// File: rtl/occ_freq_ctrl.sv
module occ_freq_ctrl #(
  parameter int N_LINKS = 3,
  parameter int OCC_W   = 8,
  parameter int GAIN_W  = 8,
  parameter int OUT_W   = 10,
  parameter int CNT_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [N_LINKS*OCC_W-1:0] occ_lvl,
  input  logic [N_LINKS*OCC_W-1:0] occ_ref,
  input  logic signed [GAIN_W-1:0] gain,
  input  logic [CNT_W-1:0]         period,
  input  logic [CNT_W-1:0]         delay,
  output logic signed [OUT_W-1:0]  corr,
  output logic                     corr_wr
);
  localparam int SUM_W = OCC_W + 1 + $clog2(N_LINKS);

  logic                    sample_evt;
  logic                    apply_evt;
  logic                    capture;
  logic signed [SUM_W-1:0] err_sum;
  logic signed [OUT_W-1:0] fresh_val;
  logic signed [OUT_W-1:0] pend_q;

  ofc_tick_sched #(.CNT_W(CNT_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period(period), .delay(delay),
    .sample_evt(sample_evt), .apply_evt(apply_evt), .capture(capture)
  );

  ofc_err_sum #(.N_LINKS(N_LINKS), .OCC_W(OCC_W), .SUM_W(SUM_W)) u_sum (
    .occ_lvl(occ_lvl), .occ_ref(occ_ref), .err_sum(err_sum)
  );

  ofc_gain_sat #(.SUM_W(SUM_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W)) u_gain (
    .err_sum(err_sum), .gain(gain), .val_o(fresh_val)
  );

  // Capture holds a sample; the write edge forwards a same-edge capture (R3).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      corr    <= '0;
      corr_wr <= 1'b0;
    end else begin
      if (capture) pend_q <= fresh_val;
      corr_wr <= apply_evt;
      if (apply_evt) corr <= capture ? fresh_val : pend_q;
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    corr_wr |=> !corr_wr); // R4
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !corr_wr |-> $stable(corr)); // R5
  AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    corr_wr |-> $past(tick)); // R3
endmodule

// File: tb/tb_occ_freq_ctrl.sv
module tb_occ_freq_ctrl;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic [23:0]       occ_lvl = '0;
  logic [23:0]       occ_ref = '0;
  logic signed [7:0] gain = '0;
  logic [7:0]        period = 8'd2;
  logic [7:0]        delay = 8'd1;
  logic signed [9:0] corr;
  logic              corr_wr;

  int          vecs = 0;
  int          bad = 0;
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  occ_freq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .occ_lvl(occ_lvl), .occ_ref(occ_ref),
    .gain(gain), .period(period), .delay(delay), .corr(corr), .corr_wr(corr_wr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // Expected word: sum of differences times gain, pinned to [-512, 511].
  function automatic longint expect_word(input logic [23:0] lv, input logic [23:0] rf,
                                         input int g);
    longint acc = 0;
    for (int i = 0; i < 3; i++) acc += longint'(lv[i*8 +: 8]) - longint'(rf[i*8 +: 8]);
    acc = acc * g;
    return (acc > 511) ? 511 : ((acc < -512) ? -512 : acc);
  endfunction

  task automatic run_cfg(input int p, input int l, input int g, input int nt);
    longint      cur = 0;
    longint      pend = 0;
    logic [23:0] nxt;
    period = 8'(p);
    delay  = 8'(l);
    gain   = 8'(g);
    occ_ref = {8'd200, 8'(50 + p), 8'd100};
    @(negedge clk);
    rst_n = 1'b0;
    tick  = 1'b0;
    repeat (3) @(negedge clk);
    chk(corr == 0 && corr_wr == 0, "R8 reset", corr, 0);
    rst_n = 1'b1;
    for (int k = 0; k < nt; k++) begin
      int gap = (k * 7 + p) % 3;
      for (int c = 0; c < gap; c++) begin
        @(negedge clk);
        chk(corr_wr == 0 && corr == cur, "R5 idle hold", corr, cur);
      end
      if (k % p == 0) begin
        int m = (k / p) % 4;
        seed = seed * 1103515245 + 12345;
        case (m)
          0: nxt = seed[31:8];
          1: nxt = 24'hFFFFFF;
          2: nxt = 24'h000000;
          default: nxt = occ_ref;
        endcase
        pend = expect_word(nxt, occ_ref, g);
        occ_lvl = nxt ^ 24'h5A5A5A;
      end
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      if (k % p == 0) occ_lvl = nxt;
      if (k >= l && k % p == l) begin
        cur = pend;
        chk(corr_wr == 1, "R4 strobe", corr_wr, 1);
        chk(corr == cur, "R3 R6 R7 R9 written word", corr, cur);
      end else if (k < l) begin
        chk(corr_wr == 0 && corr == 0, "R8 before first write", corr, 0);
      end else begin
        chk(corr_wr == 0 && corr == cur, "R1 R5 off-phase tick", corr, cur);
      end
    end
    repeat (2) begin
      @(negedge clk);
      chk(corr_wr == 0 && corr == cur, "R4 tail", corr, cur);
    end
  endtask

  initial begin
    run_cfg(2, 1, 1, 24);      // R3 same-edge capture and write
    run_cfg(3, 1, -1, 32);     // R2 post-edge capture
    run_cfg(4, 3, 2, 40);      // R10 delay = period-1
    run_cfg(5, 2, -3, 40);
    run_cfg(6, 5, 127, 48);    // R7 clamp high and low
    run_cfg(7, 4, -128, 48);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule